// File: doc/BRIEF.md
# MDIO management frame master

This block is a register-mapped master for the two-wire PHY management bus. Software writes a control word to set the MDC clock divisor and choose whether a preamble is sent. It then writes one 32-bit frame word. The block serialises that word, most significant bit first, onto the management data line, and can precede it with a run of ones. The frame fields are composed entirely by software. The block itself interprets only the start flag in bit 30 and the read flag in bit 29.

For a read frame, the block stops driving the data line from the turnaround bit onward. It captures the sixteen data bits the PHY returns and presents them in the low half of the data register. When the last bit has gone by, a completion flag in the control register is set. Software polls that flag. Writing a control word whose low byte is zero ends the session, disables the engine and aborts any frame in flight.

A PHY-select transaction needs no special support. Software builds it as an ordinary write frame to register address 0x1F, with the PHY number shifted left by four in the data field.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, MDC is low, the data line is not driven, and both registers read as zero.
- R2: The control register sits at offset 0x128 and the data register at 0x12C. Control bits 6:0 hold the divisor, bit 7 enables the preamble, and bit 8 is the read-only completion flag. A control write made while idle reads back its divisor and preamble bits.
- R3: While a frame runs, MDC has a period of 2*(divisor+1) system clocks, with a low half followed by a high half for each bit. MDC stays low while idle.
- R4: When the preamble bit is set, 32 driven ones precede the frame. When it is clear, the frame's first bit is the first bit sent.
- R5: Frame bits go out from bit 31 down to bit 0. Each bit changes only when MDC falls, and it is stable across the MDC rising edge.
- R6: A frame with bit 29 clear drives all 32 of its bits. After such a frame, the data register reads zero.
- R7: A frame with bit 29 set releases the data line for frame bits 17 down to 0. It samples the line on the MDC rising edges of bits 15 down to 0, first sample into bit 15. The captured value appears in data register bits 15:0, and bits 31:16 read zero.
- R8: Control bit 8 becomes 1 after the last bit of a frame has completed. It becomes 0 when the next frame starts.
- R9: A data register write made while a frame is in progress is ignored.
- R10: A data register write with bit 30 clear starts no frame. So does a data write made while the engine is disabled, that is, after reset or after a stop.
- R11: A control write whose bits 7:0 are all zero aborts any frame. It forces MDC low, releases the data line, clears the completion flag and the control fields, and disables the engine. This also applies to a divisor of 0 written without the preamble bit.
- R12: A control write with a nonzero low byte is ignored while a frame is in progress. The divisor and preamble setting in use are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o (1 = drive) |
| mdio_i | input | 1 | Management data read back from the pad |

## Verification
A wrong bit counter shows at the pins in two ways. The number of MDC rising edges per frame is off, or the completion flag appears early or late; both are visible within one frame. A wrong direction state shows as the enable asserted during a read's turnaround, or dropped during a write. A slip of the shift register shows as a wrong bit at a specific rising edge, and the bench compares every edge. Divider faults show at the first MDC period, because every period is timed against the programmed divisor. A wrong capture path shows in the data register as soon as the read completes.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h128,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h12C,
  parameter int DIV_W = 7,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_W  = 32;
  localparam int RD_W     = 16;
  localparam int TOT_W    = PRE_LEN + FRAME_W;
  localparam int BL_W     = $clog2(TOT_W + 1);
  localparam int PRE_BIT  = 7;
  localparam int DONE_BIT = 8;
  localparam int TA_LEFT  = 18;

  logic             armed, busy, done_q, pre_q, rd_q, mdc_q;
  logic [DIV_W-1:0] div_q, hcnt;
  logic [BL_W-1:0]  bits_left;
  logic [31:0]      word;
  logic [RD_W-1:0]  rx;

  wire ctrl_hit = reg_wr && (reg_addr == CTRL_OFF);
  wire data_hit = reg_wr && (reg_addr == DATA_OFF);
  wire stop_wr  = ctrl_hit && (reg_wdata[7:0] == 8'd0);
  wire go       = data_hit && armed && !busy && reg_wdata[30];
  wire tick     = busy && (hcnt == div_q);
  wire in_pre   = bits_left > BL_W'(FRAME_W);
  wire sample   = rd_q && (bits_left <= BL_W'(RD_W));

  assign mdc     = mdc_q;
  assign mdio_o  = busy && (in_pre || word[31]);
  assign mdio_oe = busy && !(rd_q && bits_left <= BL_W'(TA_LEFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; busy <= 1'b0; done_q <= 1'b0; pre_q <= 1'b0;
      rd_q <= 1'b0; mdc_q <= 1'b0; div_q <= '0; hcnt <= '0;
      bits_left <= '0; word <= '0; rx <= '0;
    end else if (stop_wr) begin
      armed <= 1'b0; busy <= 1'b0; done_q <= 1'b0; pre_q <= 1'b0;
      mdc_q <= 1'b0; div_q <= '0; hcnt <= '0;
    end else begin
      if (ctrl_hit && !busy) begin
        armed <= 1'b1;
        div_q <= reg_wdata[DIV_W-1:0];
        pre_q <= reg_wdata[PRE_BIT];
      end
      if (go) begin
        busy      <= 1'b1;
        done_q    <= 1'b0;
        word      <= reg_wdata;
        rd_q      <= reg_wdata[29];
        bits_left <= pre_q ? BL_W'(TOT_W) : BL_W'(FRAME_W);
        rx        <= '0;
        hcnt      <= '0;
        mdc_q     <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          hcnt <= '0;
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (sample) rx <= {rx[RD_W-2:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (!in_pre) word <= {word[30:0], 1'b0};
            if (bits_left == BL_W'(1)) begin
              busy   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFF) begin
      reg_rdata[DIV_W-1:0] = div_q;
      reg_rdata[PRE_BIT]   = pre_q;
      reg_rdata[DONE_BIT]  = done_q;
    end else if (reg_addr == DATA_OFF) begin
      reg_rdata[RD_W-1:0] = rx;
    end
  end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h128,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h12C,
  parameter int DIV_W = 7,
  parameter int BL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              done_q,
  input logic              armed,
  input logic              pre_q,
  input logic              rd_q,
  input logic [BL_W-1:0]   bits_left,
  input logic [DIV_W-1:0]  div_q
);
  wire data_w = reg_wr && (reg_addr == DATA_OFF);
  wire ctrl_w = reg_wr && (reg_addr == CTRL_OFF);

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R3
  AST_PREAMBLE_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && pre_q |-> mdio_o && mdio_oe); // R4
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mdc && $past(busy) |-> $stable(mdio_o) && $stable(mdio_oe)); // R5
  AST_DONE_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done_q); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && armed |-> done_q); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_w |=> $stable(rd_q) &&
      (bits_left == $past(bits_left) || bits_left == $past(bits_left) - 1'b1)); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && reg_wdata[7:0] == 8'd0 |=> !mdc && !mdio_oe && !done_q && !armed); // R11
  AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_w && reg_wdata[7:0] != 8'd0 |=> $stable(div_q) && $stable(pre_q)); // R12
endmodule

bind mdio_frame_master mdio_frame_master_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .DATA_OFF(DATA_OFF),
  .DIV_W(DIV_W), .BL_W(BL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done_q(done_q), .armed(armed), .pre_q(pre_q), .rd_q(rd_q),
  .bits_left(bits_left), .div_q(div_q)
);

// File: tb/test_mdio_frame_master.sv
`timescale 1ns/1ps
module test_mdio_frame_master;
  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] DATA = 12'h12C;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  int nchk = 0, nfail = 0;
  int nrise = 0, per_err = 0;
  time last_rise = 0;
  bit cur_pre = 1'b0;
  int cur_div = 0;
  logic [15:0] reply_q = '0;
  logic [127:0] seen_o, seen_oe;

  mdio_frame_master i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #4 clk = ~clk;

  always @(posedge mdc) begin
    if (nrise > 0 && ($time - last_rise) != time'(16 * (cur_div + 1))) per_err++;
    last_rise = $time;
    if (nrise < 128) begin
      seen_o[nrise]  = mdio_o;
      seen_oe[nrise] = mdio_oe;
    end
    nrise++;
  end

  always @(negedge mdc) begin
    int p;
    p = 31 - (nrise - (cur_pre ? 32 : 0));
    if (p >= 0 && p <= 15) mdio_i = reply_q[p];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      rd(CTRL, v);
      ok = v[8];
    end
  endtask

  function automatic bit exp_bit(input logic [31:0] w, input bit pre, input int i);
    if (pre && i < 32) return 1'b1;
    return w[31 - (i - (pre ? 32 : 0))];
  endfunction

  function automatic bit exp_oe(input logic [31:0] w, input bit pre, input int i);
    int p;
    if (pre && i < 32) return 1'b1;
    p = 31 - (i - (pre ? 32 : 0));
    return !(w[29] && p <= 17);
  endfunction

  function automatic logic [31:0] frame(input bit rdf, input logic [4:0] dev,
                                        input logic [3:0] ra, input logic [15:0] d);
    logic [31:0] w;
    w = 32'h0;
    w[30] = 1'b1;
    w[29] = rdf;
    w[28] = !rdf;
    w[17] = 1'b1;
    w[26:22] = dev;
    w[21:18] = ra;
    if (!rdf) w[15:0] = d;
    return w;
  endfunction

  task automatic start_frame(input bit pre, input int div, input logic [31:0] w,
                             input logic [15:0] reply);
    logic [31:0] v;
    cur_pre = pre; cur_div = div; reply_q = reply;
    wr(CTRL, {23'h0, pre, 7'(div)});
    nrise = 0; per_err = 0;
    wr(DATA, w);
    rd(CTRL, v);
    check(v[8] == 1'b0, "R8", "done cleared at start", {31'h0, v[8]}, 32'h0);
  endtask

  task automatic finish_frame(input bit pre, input logic [31:0] w, input logic [15:0] reply);
    bit ok;
    int tot, bad_pre, bad_frm, bad_oe;
    logic [31:0] v;
    wait_done(ok);
    check(ok, "R8", "done set after last bit", {31'h0, ok}, 32'h1);
    tot = (pre ? 64 : 32);
    check(nrise == tot, "R4", "MDC rising edge count", nrise, tot);
    bad_pre = 0; bad_frm = 0; bad_oe = 0;
    for (int i = 0; i < tot && i < nrise; i++) begin
      if (seen_oe[i] != exp_oe(w, pre, i)) bad_oe++;
      if (exp_oe(w, pre, i) && seen_o[i] != exp_bit(w, pre, i)) begin
        if (pre && i < 32) bad_pre++; else bad_frm++;
      end
    end
    if (pre) check(bad_pre == 0, "R4", "preamble ones", bad_pre, 0);
    check(bad_frm == 0, "R5", "frame bits MSB first", bad_frm, 0);
    check(bad_oe == 0, w[29] ? "R7" : "R6", "drive enable pattern", bad_oe, 0);
    check(per_err == 0, "R3", "MDC period", per_err, 0);
    rd(DATA, v);
    if (w[29]) check(v == {16'h0, reply}, "R7", "read data", v, {16'h0, reply});
    else       check(v == 32'h0, "R6", "data reg after write frame", v, 32'h0);
  endtask

  initial begin
    #(8 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int n;
    bit ok;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins idle at reset",
          {30'h0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    rd(CTRL, v); check(v == 32'h0, "R1", "control after reset", v, 32'h0);
    rd(DATA, v); check(v == 32'h0, "R1", "data after reset", v, 32'h0);

    // R10: engine disabled after reset
    wr(DATA, frame(1'b0, 5'd1, 4'd2, 16'h1234));
    repeat (100) @(negedge clk);
    check(nrise == 0, "R10", "data write while disabled", nrise, 0);

    // R2: control readback
    wr(CTRL, 32'h85);
    rd(CTRL, v); check(v == 32'h85, "R2", "control readback", v, 32'h85);

    // PHY-select write with preamble
    w = 32'h4000_0000 | 32'h1000_0000 | 32'h0002_0000 | (32'h1F << 18) | (32'd5 << 4);
    start_frame(1'b1, 2, w, 16'h0); finish_frame(1'b1, w, 16'h0);

    // reads
    w = frame(1'b1, 5'd3, 4'd7, 16'h0);
    start_frame(1'b0, 1, w, 16'hA5C3); finish_frame(1'b0, w, 16'hA5C3);
    w = frame(1'b1, 5'd31, 4'd1, 16'h0);
    start_frame(1'b1, 0, w, 16'h8001); finish_frame(1'b1, w, 16'h8001);

    // R9 and R12: writes during a frame
    w = frame(1'b0, 5'd9, 4'd4, 16'hBEEF);
    start_frame(1'b0, 3, w, 16'h0);
    repeat (40) @(negedge clk);
    wr(DATA, frame(1'b1, 5'd2, 4'd2, 16'h0));
    wr(CTRL, 32'h81);
    finish_frame(1'b0, w, 16'h0);
    rd(CTRL, v);
    check(v == 32'h103, "R12", "control held during frame", v, 32'h103);
    n = nrise;
    repeat (150) @(negedge clk);
    check(nrise == n, "R9", "no frame queued by busy write", nrise, n);

    // R10: start flag clear
    wr(DATA, frame(1'b0, 5'd1, 4'd1, 16'h1) & ~32'h4000_0000);
    repeat (150) @(negedge clk);
    check(nrise == n, "R10", "start bit clear ignored", nrise, n);

    // R11: stop mid frame
    w = frame(1'b0, 5'd6, 4'd6, 16'h5555);
    start_frame(1'b1, 2, w, 16'h0);
    repeat (100) @(negedge clk);
    wr(CTRL, 32'hFFFF_FF00);
    @(negedge clk); #1;
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R11", "pins released on stop",
          {30'h0, mdc, mdio_oe}, 32'h0);
    rd(CTRL, v); check(v == 32'h0, "R11", "control cleared on stop", v, 32'h0);
    n = nrise;
    wr(DATA, w);
    repeat (200) @(negedge clk);
    check(nrise == n, "R11", "engine disabled after stop", nrise, n);
    rd(CTRL, v); check(v[8] == 1'b0, "R11", "done stays clear", {31'h0, v[8]}, 32'h0);

    // random frames
    for (int k = 0; k < 14; k++) begin
      bit pre, rdf;
      int div;
      logic [15:0] rep;
      pre = 1'($urandom);
      rdf = 1'($urandom);
      div = int'($urandom % 6);
      if (!pre && div == 0) div = 1;
      rep = 16'($urandom);
      w = frame(rdf, 5'($urandom), 4'($urandom), 16'($urandom));
      start_frame(pre, div, w, rep);
      finish_frame(pre, w, rep);
    end

    wait_done(ok);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule